// File: doc/BRIEF.md
# Power-Management Interrupt Combiner

This block gathers interrupt requests from eight on-chip sources and merges them into one active-low system-management interrupt line. That line has the highest priority in the system and cannot be masked. The sources are the parallel port, two serial ports, the floppy controller, the watchdog, the mouse, the keyboard and the infrared port. Firmware programs a per-source enable for each one. A source's live request only reaches the group when its enable is set. The merged request then drives the pin only when a separate group gate bit is also set.

Every source event also sets a sticky status bit, whether or not that source is enabled, so software can always see what happened. Status bits are cleared by writing 1 to them. A routing bit can also feed an auxiliary keyboard-controller line into the group request. Four byte-wide registers on a plain read/write bus give access to all of this. Reads are combinational and writes take effect on the clock edge.

Top module: `pm_irq_combiner`

## Requirements
- R1: After reset `smi_n` is 1 and all four registers read 0x00.
- R2: Register 0 (enable A) holds source enables in bits 0..5: parallel, serial 2, serial 1, floppy, watchdog, mouse. Register 1 (enable B) holds keyboard enable in bit 0, infrared enable in bit 1, auxiliary routing in bit 6 and the group gate in bit 7. Written values read back, and all unused bits read 0.
- R3: `src_req` bit order is 0 parallel, 1 serial 2, 2 serial 1, 3 floppy, 4 watchdog, 5 mouse, 6 keyboard, 7 infrared. When the group gate is 1 and any request bit is high with its enable set, `smi_n` is 0 in the cycle after that clock edge. Otherwise it is 1.
- R4: While the group gate is 0, `smi_n` stays 1 whatever the requests and enables are.
- R5: A high request bit sets its status bit, even with its enable clear. Register 2 (status A) shows sources 0..5 in bits 0..5, and register 3 (status B) shows keyboard in bit 0 and infrared in bit 1. The bit stays set after the request drops.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: If a request is high in the same cycle that a write of 1 clears its status bit, the bit stays set.
- R8: With routing bit 1, a high `aux_kbd` acts as an enabled group request. With routing bit 0, `aux_kbd` has no effect on `smi_n`.
- R9: Reading any register changes no register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 8 | Per-source interrupt requests, active high |
| aux_kbd | input | 1 | Auxiliary keyboard-controller line, active high |
| reg_addr | input | 2 | Register select 0..3 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| smi_n | output | 1 | Group system-management interrupt, active low, registered |

## Verification
Register reads are combinational, so a read value reflects any write from the preceding clock edge. A status bit becomes visible one edge after its request is sampled. `smi_n` also changes exactly one edge after the requests, enables or gate that produce it. The bench drives all inputs on the falling edge and samples results at the next falling edge, with one rising edge in between, so each check lands on the first cycle its result is due. Tests where nothing should change (gate closed, routing off, reads) sample after the same single edge. A late or spurious change would therefore show up.

// File: rtl/pm_irq_combiner.sv
module pm_irq_combiner #(
  parameter int NSRC = 8,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic          aux_kbd,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          smi_n
);
  localparam int NA = 6;
  localparam int NB = NSRC - NA;

  logic [NA-1:0]   en_a;
  logic [NB-1:0]   en_b;
  logic            route_aux;
  logic            grp_gate;
  logic [NSRC-1:0] stat;
  logic [NSRC-1:0] clr;
  logic            grp_req;

  wire wr_a  = reg_wr && reg_addr == 2'd0;
  wire wr_b  = reg_wr && reg_addr == 2'd1;
  wire wr_sa = reg_wr && reg_addr == 2'd2;
  wire wr_sb = reg_wr && reg_addr == 2'd3;

  assign clr = ({NSRC{wr_sa}} & {{NB{1'b0}}, reg_wdata[NA-1:0]})
             | ({NSRC{wr_sb}} & {reg_wdata[NB-1:0], {NA{1'b0}}});

  assign grp_req = (|(src_req & {en_b, en_a})) | (route_aux & aux_kbd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a      <= '0;
      en_b      <= '0;
      route_aux <= 1'b0;
      grp_gate  <= 1'b0;
      stat      <= '0;
      smi_n     <= 1'b1;
    end else begin
      if (wr_a) en_a <= reg_wdata[NA-1:0];
      if (wr_b) begin
        en_b      <= reg_wdata[NB-1:0];
        route_aux <= reg_wdata[6];
        grp_gate  <= reg_wdata[7];
      end
      stat  <= (stat & ~clr) | src_req;
      smi_n <= ~(grp_gate & grp_req);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[NA-1:0] = en_a;
      2'd1: begin
        reg_rdata[NB-1:0] = en_b;
        reg_rdata[6]      = route_aux;
        reg_rdata[7]      = grp_gate;
      end
      2'd2: reg_rdata[NA-1:0] = stat[NA-1:0];
      default: reg_rdata[NB-1:0] = stat[NSRC-1:NA];
    endcase
  end
endmodule

// File: rtl/pm_irq_combiner_chk.sv
module pm_irq_combiner_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_req,
  input logic [1:0]      reg_addr,
  input logic            reg_wr,
  input logic            grp_gate,
  input logic [NSRC-1:0] en_all,
  input logic [NSRC-1:0] stat,
  input logic            smi_n
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> smi_n);

  p_gate_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_gate |=> smi_n);

  p_group_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_gate && |(src_req & en_all)) |=> !smi_n);

  p_status_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |src_req |=> ((stat & $past(src_req)) == $past(src_req)));

  p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr[1]) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

bind pm_irq_combiner pm_irq_combiner_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .grp_gate(grp_gate), .en_all({en_b, en_a}),
  .stat(stat), .smi_n(smi_n)
);

// File: tb/test_pm_irq_combiner.sv
module test_pm_irq_combiner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_req = '0;
  logic       aux_kbd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       smi_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pm_irq_combiner i_pm_irq_combiner (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .aux_kbd(aux_kbd),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .smi_n(smi_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 reg", v, 8'h00);
    end
    check("R1 smi_n", {7'b0, smi_n}, 8'h01);
  endtask

  task automatic t_enables;
    logic [7:0] v;
    wr(2'd0, 8'hFF); rd(2'd0, v); check("R2 enA unused", v, 8'h3F);
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R2 enB unused", v, 8'hC3);
    wr(2'd0, 8'h15); rd(2'd0, v); check("R2 enA value", v, 8'h15);
    wr(2'd1, 8'h02); rd(2'd1, v); check("R2 enB value", v, 8'h02);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
  endtask

  task automatic t_group;
    wr(2'd0, 8'h01); wr(2'd1, 8'h81);
    src_req = 8'h01; step; check("R3 parallel", {7'b0, smi_n}, 8'h00);
    src_req = 8'h02; step; check("R3 disabled src", {7'b0, smi_n}, 8'h01);
    src_req = 8'h40; step; check("R3 keyboard", {7'b0, smi_n}, 8'h00);
    src_req = 8'h80; step; check("R3 infrared disabled", {7'b0, smi_n}, 8'h01);
    src_req = 8'h00; step; check("R3 idle", {7'b0, smi_n}, 8'h01);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
  endtask

  task automatic t_gate;
    wr(2'd0, 8'h3F); wr(2'd1, 8'h43);
    src_req = 8'hFF; aux_kbd = 1'b1; step;
    check("R4 gate closed", {7'b0, smi_n}, 8'h01);
    step; check("R4 gate closed hold", {7'b0, smi_n}, 8'h01);
    src_req = 8'h00; aux_kbd = 1'b0;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
  endtask

  task automatic t_status;
    logic [7:0] v;
    src_req = 8'hA4; step; src_req = 8'h00; step;
    rd(2'd2, v); check("R5 statA", v, 8'h24);
    rd(2'd3, v); check("R5 statB", v, 8'h02);
    wr(2'd2, 8'h04); rd(2'd2, v); check("R6 w1c", v, 8'h20);
    wr(2'd3, 8'h00); rd(2'd3, v); check("R6 w0 keeps", v, 8'h02);
    wr(2'd3, 8'h02); rd(2'd3, v); check("R6 w1c B", v, 8'h00);
    wr(2'd2, 8'h20);
  endtask

  task automatic t_setwins;
    logic [7:0] v;
    src_req = 8'h08; step; 
    reg_addr = 2'd2; reg_wdata = 8'h08; reg_wr = 1'b1;
    step; reg_wr = 1'b0; src_req = 8'h00;
    rd(2'd2, v); check("R7 set wins", v, 8'h08);
    wr(2'd2, 8'h08); rd(2'd2, v); check("R7 later clear", v, 8'h00);
  endtask

  task automatic t_aux;
    wr(2'd1, 8'h80);
    aux_kbd = 1'b1; step; check("R8 route off", {7'b0, smi_n}, 8'h01);
    wr(2'd1, 8'hC0); step; check("R8 route on", {7'b0, smi_n}, 8'h00);
    aux_kbd = 1'b0; step; check("R8 aux low", {7'b0, smi_n}, 8'h01);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_readclean;
    logic [7:0] v;
    src_req = 8'h11; step; src_req = 8'h00;
    for (int k = 0; k < 3; k++) begin rd(2'd2, v); step; end
    rd(2'd2, v); check("R9 read keeps status", v, 8'h11);
    wr(2'd2, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step;
    t_reset; t_enables; t_group; t_gate; t_status; t_setwins; t_aux; t_readclean;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule